// File: doc/BRIEF.md
# SPI Status and Data Register Front End

This block is the register-side front end of an 8-bit SPI peripheral. A CPU reaches it over a simple register bus with an address, a read strobe, a write strobe, write data and registered read data. It holds three event flags: receive-complete, transmit-empty and mode-fault. It keeps the last received byte and a transmit holding register, and it drives two interrupt requests. The shift engine, clock generation and the control registers live elsewhere. The shift engine supplies a received byte with a strobe, a strobe for taking the holding byte, the slave-select pin level, and the master-mode and fault-detection enables.

No flag is cleared by writing to the status register. Software first reads the status register while the flag is 1, which arms that flag. It then makes the matching second access: a data read for receive-complete, a data write for transmit-empty, or a write to control register 1 for mode-fault. A data write is accepted into the holding register only when the transmit-empty flag was armed, and is dropped otherwise.

Bus map: address 0 is status, address 1 is data, address 2 is control register 1 (only the access itself is seen here), and address 3 reads as zero.

Top module: `spi_flag_front`

## Requirements
- R1: After reset the status register reads 0x20, the data register reads 0x00, the holding register is 0x00 and both interrupt outputs are 0.
- R2: A status read returns receive-complete in bit 7, transmit-empty in bit 5 and mode-fault in bit 4, with every other bit 0. Read data from any read appears on the clock edge that ends the strobe cycle and is held until the next read.
- R3: A write to the status register changes no flag and no arm state.
- R4: A received-byte strobe loads the byte into the data register and sets receive-complete at the same edge.
- R5: Receive-complete clears only when a data read follows a status read that saw it at 1. A data read that is not armed in this way leaves it set.
- R6: A data write loads the holding register and clears transmit-empty only if a status read that saw transmit-empty at 1 came before it. Any other data write leaves the holding register unchanged.
- R7: A pulse on the transmit-load strobe sets transmit-empty.
- R8: Mode-fault sets on a high-to-low step of the slave-select input only while master mode and fault detection are both enabled.
- R9: Mode-fault clears only when a write to control register 1 follows a status read that saw it at 1.
- R10: When a flag's set condition and its armed clearing access fall in the same cycle, the flag stays set.
- R11: Each status read reloads every arm bit from its flag's current value, so a read that sees a flag at 0 disarms it. The second access always consumes the arm, armed or not.
- R12: The receive interrupt is the receive-interrupt enable ANDed with (receive-complete OR mode-fault). The transmit interrupt is the transmit-interrupt enable ANDed with transmit-empty. Both are registered one cycle behind the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register select: 0 status, 1 data, 2 control 1 |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| rx_byte | input | DW | Byte from the shift engine |
| rx_strobe | input | 1 | Received byte valid |
| tx_load | input | 1 | Shift engine takes the holding byte |
| tx_hold | output | DW | Transmit holding register |
| ss_n | input | 1 | Slave-select pin level |
| master_mode | input | 1 | Block acts as master |
| fault_det_en | input | 1 | Mode-fault detection enabled |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq | output | 1 | Receive or fault interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Flags, arm bits, the data register and the holding register all change on the edge that ends the strobe cycle. Read data from a strobe is on the bus after that same edge, and interrupts follow the flags one edge later. The bench drives inputs on falling edges and updates a behavioural model on the rising edge. It compares read data, the holding register and both interrupts at every falling edge, so each result is checked half a cycle after the edge that produced it. The directed steps are status and data reads placed between single stimulus cycles, and each of them sees the result of the previous access.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int NFLAG = 3;
  localparam int F_RX  = 0;
  localparam int F_TX  = 1;
  localparam int F_FLT = 2;

  localparam int A_STAT = 0;
  localparam int A_DATA = 1;
  localparam int A_CTL1 = 2;

  localparam int B_RX  = 7;
  localparam int B_TX  = 5;
  localparam int B_FLT = 4;

  localparam logic [NFLAG-1:0] FLAG_RST = 3'b010;
endpackage

// File: rtl/sff_flag_cell.sv
module sff_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic look_i,
  input  logic take_i,
  output logic flag_o,
  output logic arm_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= RST_VAL;
      arm_o  <= 1'b0;
    end else begin
      if (set_i)
        flag_o <= 1'b1;
      else if (take_i && arm_o)
        flag_o <= 1'b0;
      if (take_i)
        arm_o <= 1'b0;
      else if (look_i)
        arm_o <= flag_o;
    end
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  a_r11_take_consumes: assert property (@(posedge clk) disable iff (rst)
    take_i |=> !arm_o);
  a_r11_arm_from_look: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_o) |-> $past(look_i && flag_o));
  a_r5_unarmed_holds: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !arm_o) |=> flag_o);
endmodule

// File: rtl/sff_fault_edge.sv
module sff_fault_edge (
  input  logic clk,
  input  logic rst,
  input  logic ss_n,
  input  logic master_mode,
  input  logic fault_det_en,
  output logic fault_set
);
  logic ss_prev;

  always_ff @(posedge clk) begin
    if (rst) ss_prev <= 1'b1;
    else     ss_prev <= ss_n;
  end

  always_comb fault_set = ss_prev && !ss_n && master_mode && fault_det_en;

  a_r8_edge_only: assert property (@(posedge clk) disable iff (rst)
    fault_set |-> $past(ss_n));
endmodule

// File: rtl/sff_tx_hold.sv
module sff_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst)         hold <= '0;
    else if (accept) hold <= wdata;
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(hold));
  a_r6_hold_load: assert property (@(posedge clk) disable iff (rst)
    accept |=> hold == $past(wdata));
endmodule

// File: rtl/spi_flag_front.sv
module spi_flag_front #(
  parameter int ADDR_W = 2,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     rx_byte,
  input  logic              rx_strobe,
  input  logic              tx_load,
  output logic [DW-1:0]     tx_hold,
  input  logic              ss_n,
  input  logic              master_mode,
  input  logic              fault_det_en,
  input  logic              rx_irq_en,
  input  logic              tx_irq_en,
  output logic              rx_irq,
  output logic              tx_irq
);
  import sff_pkg::*;

  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
  localparam logic [ADDR_W-1:0] AD_CTL1 = ADDR_W'(A_CTL1);
  localparam logic [DW-1:0] STAT_MASK =
    (DW'(1) << B_RX) | (DW'(1) << B_TX) | (DW'(1) << B_FLT);

  logic sel_stat, sel_data, sel_ctl1;
  logic rd_stat, rd_data, wr_stat, wr_data, wr_ctl1;
  logic fault_set;
  logic [NFLAG-1:0] f_set, f_take, f_flag, f_arm;
  logic [DW-1:0] rx_data, stat_byte;

  always_comb begin
    sel_stat = (bus_addr == AD_STAT);
    sel_data = (bus_addr == AD_DATA);
    sel_ctl1 = (bus_addr == AD_CTL1);
    rd_stat  = bus_rd && sel_stat;
    rd_data  = bus_rd && sel_data;
    wr_stat  = bus_wr && sel_stat;
    wr_data  = bus_wr && sel_data;
    wr_ctl1  = bus_wr && sel_ctl1;
  end

  sff_fault_edge u_fault (
    .clk          (clk),
    .rst          (rst),
    .ss_n         (ss_n),
    .master_mode  (master_mode),
    .fault_det_en (fault_det_en),
    .fault_set    (fault_set)
  );

  always_comb begin
    f_set[F_RX]   = rx_strobe;
    f_set[F_TX]   = tx_load;
    f_set[F_FLT]  = fault_set;
    f_take[F_RX]  = rd_data;
    f_take[F_TX]  = wr_data;
    f_take[F_FLT] = wr_ctl1;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    sff_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (f_set[i]),
      .look_i (rd_stat),
      .take_i (f_take[i]),
      .flag_o (f_flag[i]),
      .arm_o  (f_arm[i])
    );
  end

  sff_tx_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .accept (wr_data && f_arm[F_TX]),
    .wdata  (bus_wdata),
    .hold   (tx_hold)
  );

  always_ff @(posedge clk) begin
    if (rst)            rx_data <= '0;
    else if (rx_strobe) rx_data <= rx_byte;
  end

  always_comb begin
    stat_byte        = '0;
    stat_byte[B_RX]  = f_flag[F_RX];
    stat_byte[B_TX]  = f_flag[F_TX];
    stat_byte[B_FLT] = f_flag[F_FLT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_stat)      bus_rdata <= stat_byte;
      else if (sel_data) bus_rdata <= rx_data;
      else               bus_rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= rx_irq_en && (f_flag[F_RX] || f_flag[F_FLT]);
      tx_irq <= tx_irq_en && f_flag[F_TX];
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (bus_rdata & ~STAT_MASK) == '0);
  a_r3_status_write_inert: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !rx_strobe && !tx_load && !fault_set) |=> $stable(f_flag) && $stable(f_arm));
  a_r4_rx_load: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> rx_data == $past(rx_byte) && f_flag[F_RX]);
  a_r8_fault_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(f_flag[F_FLT]) |-> $past(master_mode && fault_det_en && !ss_n));
  a_r12_tx_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tx_irq == $past(tx_irq_en && f_flag[F_TX]));
endmodule

// File: tb/sim_spi_flag_front.sv
module sim_spi_flag_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr = '0;
  logic rd = 0, wr = 0, rxs = 0, txl = 0;
  logic [7:0] wdata = '0, rxb = '0;
  logic ss_n = 1, mst = 0, fen = 0, rxen = 0, txen = 0;
  logic [7:0] rdata, hold;
  logic rx_irq, tx_irq;

  int nchk = 0, nfail = 0, ncyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_flag_front u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .rx_byte(rxb), .rx_strobe(rxs),
    .tx_load(txl), .tx_hold(hold), .ss_n(ss_n), .master_mode(mst),
    .fault_det_en(fen), .rx_irq_en(rxen), .tx_irq_en(txen),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  // behavioural reference
  bit m_rxf, m_txe, m_flt, a_rx, a_tx, a_flt, m_ssp, m_rxi, m_txi;
  int m_data, m_hold, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_rxf = 0; m_txe = 1; m_flt = 0; a_rx = 0; a_tx = 0; a_flt = 0;
      m_ssp = 1; m_rxi = 0; m_txi = 0; m_data = 0; m_hold = 0; m_rd = 0;
    end else begin
      bit n_rxf, n_txe, n_flt;
      int sr;
      sr = (m_rxf ? 128 : 0) + (m_txe ? 32 : 0) + (m_flt ? 16 : 0);
      if (rd) m_rd = (addr == 0) ? sr : (addr == 1) ? m_data : 0;
      m_rxi = rxen && (m_rxf || m_flt);
      m_txi = txen && m_txe;
      n_rxf = rxs ? 1 : (rd && addr == 1 && a_rx) ? 0 : m_rxf;
      n_txe = txl ? 1 : (wr && addr == 1 && a_tx) ? 0 : m_txe;
      n_flt = (m_ssp && !ss_n && mst && fen) ? 1 : (wr && addr == 2 && a_flt) ? 0 : m_flt;
      if (wr && addr == 1 && a_tx) m_hold = wdata;
      if (rxs) m_data = rxb;
      if (rd && addr == 1) a_rx = 0; else if (rd && addr == 0) a_rx = m_rxf;
      if (wr && addr == 1) a_tx = 0; else if (rd && addr == 0) a_tx = m_txe;
      if (wr && addr == 2) a_flt = 0; else if (rd && addr == 0) a_flt = m_flt;
      m_rxf = n_rxf; m_txe = n_txe; m_flt = n_flt; m_ssp = ss_n;
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (!rst && !done) begin
      chk(int'(rdata), m_rd, "R2 model read data");
      chk(int'(hold), m_hold, "R6 model holding register");
      chk(int'(rx_irq), int'(m_rxi), "R12 model rx_irq");
      chk(int'(tx_irq), int'(m_txi), "R12 model tx_irq");
    end
    if (ncyc > 20000 && !done) begin
      done = 1;
      nfail++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic cyc(input logic r, input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic s, input logic [7:0] b, input logic l);
    rd = r; wr = w; addr = a; wdata = d; rxs = s; rxb = b; txl = l;
    @(negedge clk);
    rd = 0; wr = 0; rxs = 0; txl = 0;
  endtask

  task automatic rdchk(input logic [1:0] a, input int exp, input string tag);
    cyc(1, 0, a, 8'h00, 0, 8'h00, 0);
    chk(int'(rdata), exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 8'h00, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R6: unarmed data write straight after reset is dropped
    cyc(0, 1, 2'd1, 8'h5A, 0, 8'h00, 0);
    chk(int'(hold), 0, "R6 unarmed write ignored");
    // R1: reset values
    chk(int'(rx_irq) + int'(tx_irq), 0, "R1 irqs low");
    rdchk(2'd0, 8'h20, "R1 status reset");
    rdchk(2'd1, 8'h00, "R1 data reset");
    // R3: status write is inert
    cyc(0, 1, 2'd0, 8'hFF, 0, 8'h00, 0);
    rdchk(2'd0, 8'h20, "R3 status write ignored");
    // R6: armed write accepted
    cyc(0, 1, 2'd1, 8'hA5, 0, 8'h00, 0);
    chk(int'(hold), 8'hA5, "R6 armed write accepted");
    rdchk(2'd0, 8'h00, "R6 transmit-empty cleared");
    // R11: last status read saw 0, so no arm
    cyc(0, 0, 2'd0, 8'h00, 0, 8'h00, 1);
    cyc(0, 1, 2'd1, 8'h11, 0, 8'h00, 0);
    chk(int'(hold), 8'hA5, "R11 read of clear flag disarms");
    rdchk(2'd0, 8'h20, "R7 load sets transmit-empty");
    txen = 1;
    idle(1);
    chk(int'(tx_irq), 1, "R12 tx_irq with enable");
    cyc(0, 1, 2'd1, 8'h77, 0, 8'h00, 0);
    chk(int'(hold), 8'h77, "R6 armed write after reload");
    cyc(0, 1, 2'd1, 8'h88, 0, 8'h00, 0);
    chk(int'(hold), 8'h77, "R11 second write finds arm consumed");
    idle(1);
    chk(int'(tx_irq), 0, "R12 tx_irq drops with flag");
    cyc(0, 0, 2'd0, 8'h00, 0, 8'h00, 1);
    txen = 0;
    // R4 / R5: receive
    cyc(0, 0, 2'd0, 8'h00, 1, 8'h3C, 0);
    rdchk(2'd1, 8'h3C, "R4 byte in data register");
    rdchk(2'd0, 8'hA0, "R5 unarmed data read leaves flag");
    rxen = 1;
    idle(1);
    chk(int'(rx_irq), 1, "R12 rx_irq on receive");
    rdchk(2'd1, 8'h3C, "R5 armed data read");
    rdchk(2'd0, 8'h20, "R5 receive-complete cleared");
    // R10: set beats armed clear
    cyc(0, 0, 2'd0, 8'h00, 1, 8'hC3, 0);
    rdchk(2'd0, 8'hA0, "R4 flag set again");
    cyc(1, 0, 2'd1, 8'h00, 1, 8'h5A, 0);
    chk(int'(rdata), 8'hC3, "R10 read returns older byte");
    rdchk(2'd0, 8'hA0, "R10 set wins over clear");
    rdchk(2'd1, 8'h5A, "R4 newer byte loaded");
    rdchk(2'd0, 8'h20, "R5 cleared after re-arm");
    // R8 / R9: mode fault
    mst = 1; fen = 1; idle(1);
    ss_n = 0; idle(1); ss_n = 1; idle(1);
    cyc(0, 1, 2'd2, 8'h00, 0, 8'h00, 0);
    rdchk(2'd0, 8'h30, "R9 unarmed control write keeps fault");
    idle(1);
    chk(int'(rx_irq), 1, "R12 rx_irq on fault");
    cyc(0, 1, 2'd2, 8'h00, 0, 8'h00, 0);
    rdchk(2'd0, 8'h20, "R9 armed control write clears fault");
    fen = 0; ss_n = 0; idle(1); ss_n = 1; idle(1);
    rdchk(2'd0, 8'h20, "R8 no fault when detection off");
    fen = 1; mst = 0; ss_n = 0; idle(1); ss_n = 1; idle(1);
    rdchk(2'd0, 8'h20, "R8 no fault as slave");
    rdchk(2'd3, 8'h00, "R2 unused address reads zero");
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule